// File: doc/BRIEF.md
# Audio Mode-Change Gated Configuration Bank

This block is the indexed control-register bank that sits behind an audio codec's host interface. The host selects a register with an index and writes a byte, or reads one back. The bank holds the 16-bit playback DMA base, a capture base, the playback and capture data-format registers, an alternate-feature register and a filter-control register. Its decoded fields drive the DMA counters, the serial port and the ADC filter logic, none of which are part of this block.

Several fields are protected. The serial-port enable and the serial-format select change only while the global mode-change input `mce` is high. The upper nibble of each format register, which holds the channel-count and sample-encoding fields, is also writable while that channel's own mode-change enable bit is set. The playback sample-rate nibble always needs `mce`.

When the compatibility input is asserted, one base register serves both directions, and the capture-base output follows the playback base. On every DAC sample tick the block also picks the value sent to the DAC. Normally this is the incoming sample. During an underrun it is either center scale or the last good sample, according to a policy bit.

Top module: `audio_cfg_bank`

## Requirements
- R1: After reset, both base bytes, both format registers, the DAC-zero bit, both mode-change bits and the filter enable are 0. The serial enable and serial format take their values from `cfg_preset`, where bit 2 is the enable and bits 1:0 are the format. `dac_data` resets to center scale, 1 << (SAMPLE_W-1).
- R2: A write to index 14 sets `pb_base[15:8]` and a write to index 15 sets `pb_base[7:0]`, each on the next clock edge. Reading either index returns the byte last written.
- R3: While `compat_1dma` is 0, `cap_base` is formed from index 30 (bits 15:8) and index 31 (bits 7:0). While it is 1, `cap_base` equals `pb_base` in every cycle.
- R4: Index 16 holds the DAC-zero bit at bit 0, serial enable at bit 1, serial format at bits 3:2, playback mode-change enable at bit 4 and capture mode-change enable at bit 5. Bits 0, 4 and 5 accept every write. Bits 7:6 read 0.
- R5: Bits 3:1 of index 16 accept a write only while `mce` is 1 and otherwise keep their value. `serial_fmt` carries the 2-bit code unchanged to the serial port, which decodes it as 0 = 64-bit enhanced, 1 = 64-bit, 2 = 32-bit, 3 = converter-direct.
- R6: Playback format (index 8): bits 7:4 accept a write when `mce` is 1 or the playback mode-change bit is 1. Bits 3:0 (sample rate) accept a write only when `mce` is 1.
- R7: Capture format (index 28): bits 7:4 accept a write when `mce` is 1 or the capture mode-change bit is 1. Bits 3:0 read 0.
- R8: On a `dac_tick` with `underrun` high and DAC-zero set to 1, `dac_data` becomes center scale one cycle later.
- R9: On a `dac_tick` with `underrun` high and DAC-zero set to 0, `dac_data` keeps the previous valid sample.
- R10: On a `dac_tick` with `underrun` low, `dac_data` takes `pb_sample` one cycle later. Without a tick, `dac_data` does not change.
- R11: Index 17 bit 0 drives `hpf_en`. Bits 7:1, which include the test bits 7:4, discard writes and read 0.
- R12: Reads of any index other than 8, 14, 15, 16, 17, 28, 30 and 31 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the indexed register |
| addr | input | IDX_W | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| mce | input | 1 | Global mode-change enable |
| compat_1dma | input | 1 | Single-DMA compatibility mode |
| cfg_preset | input | 3 | Reset value for {serial enable, serial format} |
| pb_base | output | 16 | Playback DMA base |
| cap_base | output | 16 | Capture DMA base |
| pb_fmt | output | 8 | Playback format register |
| cap_fmt | output | 8 | Capture format register |
| serial_en | output | 1 | Serial port enable |
| serial_fmt | output | 2 | Serial frame format code |
| hpf_en | output | 1 | ADC DC-blocking filter enable |
| dac_tick | input | 1 | DAC sample strobe |
| underrun | input | 1 | Playback underrun flag for this tick |
| pb_sample | input | SAMPLE_W | Sample from the playback FIFO |
| dac_data | output | SAMPLE_W | Sample presented to the DAC |

## Verification
Register writes are tried with `mce` low and then high, and with each mode-change bit cleared and then set. These patterns separate global gating from per-channel gating, and upper-nibble gating from rate-nibble gating. Base writes use distinct upper and lower bytes, once with the compatibility input low and once with it high, so that a byte swap or a missing mirror shows up. The DAC path is driven with a normal tick, an underrun under each setting of the policy bit, and idle cycles, which separates the hold, zero and pass-through cases.

// File: rtl/audio_cfg_bank.sv
module audio_cfg_bank #(
  parameter int IDX_W    = 5,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    addr,
  input  logic [7:0]          wdata,
  output logic [7:0]          rdata,
  input  logic                mce,
  input  logic                compat_1dma,
  input  logic [2:0]          cfg_preset,
  output logic [15:0]         pb_base,
  output logic [15:0]         cap_base,
  output logic [7:0]          pb_fmt,
  output logic [7:0]          cap_fmt,
  output logic                serial_en,
  output logic [1:0]          serial_fmt,
  output logic                hpf_en,
  input  logic                dac_tick,
  input  logic                underrun,
  input  logic [SAMPLE_W-1:0] pb_sample,
  output logic [SAMPLE_W-1:0] dac_data
);
  localparam logic [IDX_W-1:0] IX_PFMT = IDX_W'(8);
  localparam logic [IDX_W-1:0] IX_PBHI = IDX_W'(14);
  localparam logic [IDX_W-1:0] IX_PBLO = IDX_W'(15);
  localparam logic [IDX_W-1:0] IX_FEAT = IDX_W'(16);
  localparam logic [IDX_W-1:0] IX_FILT = IDX_W'(17);
  localparam logic [IDX_W-1:0] IX_CFMT = IDX_W'(28);
  localparam logic [IDX_W-1:0] IX_CBHI = IDX_W'(30);
  localparam logic [IDX_W-1:0] IX_CBLO = IDX_W'(31);
  localparam logic [SAMPLE_W-1:0] CENTER = SAMPLE_W'(1) << (SAMPLE_W-1);

  logic [7:0] pb_hi, pb_lo, cb_hi, cb_lo;
  logic [3:0] pf_hi, pf_rate, cf_hi;
  logic       dacz, pmce, cmce;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pb_hi <= '0; pb_lo <= '0; cb_hi <= '0; cb_lo <= '0;
      pf_hi <= '0; pf_rate <= '0; cf_hi <= '0;
      dacz <= 1'b0; pmce <= 1'b0; cmce <= 1'b0; hpf_en <= 1'b0;
      serial_en  <= cfg_preset[2];
      serial_fmt <= cfg_preset[1:0];
    end else if (wr_en) begin
      case (addr)
        IX_PBHI: pb_hi <= wdata;
        IX_PBLO: pb_lo <= wdata;
        IX_CBHI: cb_hi <= wdata;
        IX_CBLO: cb_lo <= wdata;
        IX_FEAT: begin
          dacz <= wdata[0];
          pmce <= wdata[4];
          cmce <= wdata[5];
          if (mce) begin
            serial_en  <= wdata[1];
            serial_fmt <= wdata[3:2];
          end
        end
        IX_FILT: hpf_en <= wdata[0];
        IX_PFMT: begin
          if (mce || pmce) pf_hi <= wdata[7:4];
          if (mce) pf_rate <= wdata[3:0];
        end
        IX_CFMT: if (mce || cmce) cf_hi <= wdata[7:4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      dac_data <= CENTER;
    else if (dac_tick) begin
      if (!underrun)  dac_data <= pb_sample;
      else if (dacz)  dac_data <= CENTER;
    end
  end

  assign pb_base  = {pb_hi, pb_lo};
  assign cap_base = compat_1dma ? pb_base : {cb_hi, cb_lo};
  assign pb_fmt   = {pf_hi, pf_rate};
  assign cap_fmt  = {cf_hi, 4'b0000};

  always_comb begin
    case (addr)
      IX_PBHI: rdata = pb_hi;
      IX_PBLO: rdata = pb_lo;
      IX_CBHI: rdata = cb_hi;
      IX_CBLO: rdata = cb_lo;
      IX_FEAT: rdata = {2'b00, cmce, pmce, serial_fmt, serial_en, dacz};
      IX_FILT: rdata = {7'b0, hpf_en};
      IX_PFMT: rdata = pb_fmt;
      IX_CFMT: rdata = cap_fmt;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/audio_cfg_bank_chk.sv
module audio_cfg_bank_chk #(
  parameter int IDX_W    = 5,
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [IDX_W-1:0]    addr,
  input logic [7:0]          wdata,
  input logic [7:0]          rdata,
  input logic                mce,
  input logic                compat_1dma,
  input logic [15:0]         pb_base,
  input logic [15:0]         cap_base,
  input logic [7:0]          pb_fmt,
  input logic                serial_en,
  input logic [1:0]          serial_fmt,
  input logic                dac_zero,
  input logic                dac_tick,
  input logic                underrun,
  input logic [SAMPLE_W-1:0] pb_sample,
  input logic [SAMPLE_W-1:0] dac_data
);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W-1);

  AST_SERIAL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mce |=> $stable({serial_en, serial_fmt})); // R5
  AST_RATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mce |=> $stable(pb_fmt[3:0])); // R6
  AST_BASE_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == IDX_W'(14)) |=> pb_base[15:8] == $past(wdata)); // R2
  AST_COMPAT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    compat_1dma |-> cap_base == pb_base); // R3
  AST_UNDERRUN_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_tick && underrun && dac_zero) |=> dac_data == MID); // R8
  AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_tick && underrun && !dac_zero) |=> $stable(dac_data)); // R9
  AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_tick && !underrun) |=> dac_data == $past(pb_sample)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_tick |=> $stable(dac_data)); // R10
  AST_FILT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == IDX_W'(17)) |-> rdata[7:1] == 7'b0); // R11
endmodule

bind audio_cfg_bank audio_cfg_bank_chk #(.IDX_W(IDX_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .mce(mce), .compat_1dma(compat_1dma), .pb_base(pb_base),
  .cap_base(cap_base), .pb_fmt(pb_fmt), .serial_en(serial_en),
  .serial_fmt(serial_fmt), .dac_zero(dacz), .dac_tick(dac_tick),
  .underrun(underrun), .pb_sample(pb_sample), .dac_data(dac_data)
);

// File: tb/audio_cfg_bank_bench.sv
`timescale 1ns/1ps
module audio_cfg_bank_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mce = 1'b0, compat_1dma = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [2:0] cfg_preset = 3'b110;
  logic [15:0] pb_base, cap_base, pb_sample = '0, dac_data;
  logic [7:0] pb_fmt, cap_fmt;
  logic serial_en, hpf_en, dac_tick = 1'b0, underrun = 1'b0;
  logic [1:0] serial_fmt;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  audio_cfg_bank u_audio_cfg_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mce(mce), .compat_1dma(compat_1dma), .cfg_preset(cfg_preset),
    .pb_base(pb_base), .cap_base(cap_base), .pb_fmt(pb_fmt), .cap_fmt(cap_fmt),
    .serial_en(serial_en), .serial_fmt(serial_fmt), .hpf_en(hpf_en),
    .dac_tick(dac_tick), .underrun(underrun), .pb_sample(pb_sample),
    .dac_data(dac_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(5'd16, v); chk("R1 feature reset", v, 8'h0A);
    chk("R1 serial preset", {serial_en, serial_fmt}, 3'b110);
    chk("R1 base reset", {pb_base, cap_base}, 32'h0);
    chk("R1 fmt reset", {pb_fmt, cap_fmt, hpf_en}, 17'h0);
    chk("R1 dac center", dac_data, 16'h8000);
  endtask

  task automatic t_base;
    logic [7:0] v;
    wr(5'd14, 8'hA5); wr(5'd15, 8'h3C);
    chk("R2 pb_base", pb_base, 16'hA53C);
    rd(5'd14, v); chk("R2 read hi", v, 8'hA5);
    rd(5'd15, v); chk("R2 read lo", v, 8'h3C);
  endtask

  task automatic t_compat;
    wr(5'd30, 8'h12); wr(5'd31, 8'h34);
    chk("R3 cap own", cap_base, 16'h1234);
    @(negedge clk); compat_1dma = 1'b1; #1;
    chk("R3 cap mirror", cap_base, 16'hA53C);
    wr(5'd15, 8'h77);
    chk("R3 mirror follows", cap_base, 16'hA577);
    @(negedge clk); compat_1dma = 1'b0; #1;
    chk("R3 cap restore", cap_base, 16'h1234);
  endtask

  task automatic t_feature;
    logic [7:0] v;
    wr(5'd16, 8'hFF);
    rd(5'd16, v); chk("R5 locked, R4 free bits", v, 8'h3B);
    @(negedge clk); mce = 1'b1;
    wr(5'd16, 8'b0000_0100);
    rd(5'd16, v); chk("R4 R5 unlocked write", v, 8'h04);
    chk("R5 serial out", {serial_en, serial_fmt}, 3'b001);
    wr(5'd16, 8'b0000_1110);
    chk("R5 fmt 3 enabled", {serial_en, serial_fmt}, 3'b111);
    @(negedge clk); mce = 1'b0;
    wr(5'd16, 8'h00);
    chk("R5 ignored without mce", {serial_en, serial_fmt}, 3'b111);
  endtask

  task automatic t_fmt;
    logic [7:0] v;
    wr(5'd8, 8'hAB);  chk("R6 locked", pb_fmt, 8'h00);
    wr(5'd28, 8'hCD); chk("R7 locked", cap_fmt, 8'h00);
    wr(5'd16, 8'h10);
    wr(5'd8, 8'hAB);  chk("R6 pmce upper only", pb_fmt, 8'hA0);
    wr(5'd28, 8'hCD); chk("R7 cmce off", cap_fmt, 8'h00);
    wr(5'd16, 8'h20);
    wr(5'd28, 8'hCD); rd(5'd28, v); chk("R7 cmce upper, lower zero", v, 8'hC0);
    @(negedge clk); mce = 1'b1;
    wr(5'd8, 8'h5E);  chk("R6 mce full", pb_fmt, 8'h5E);
    @(negedge clk); mce = 1'b0;
    wr(5'd16, 8'h00);
  endtask

  task automatic t_filter;
    logic [7:0] v;
    wr(5'd17, 8'hFF);
    rd(5'd17, v); chk("R11 filter read", v, 8'h01);
    chk("R11 hpf_en", hpf_en, 1'b1);
    wr(5'd17, 8'hF0); chk("R11 hpf off", hpf_en, 1'b0);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    rd(5'd0, v);  chk("R12 idx0", v, 8'h00);
    rd(5'd29, v); chk("R12 idx29", v, 8'h00);
  endtask

  task automatic t_dac;
    @(negedge clk); pb_sample = 16'h1234; dac_tick = 1'b1; underrun = 1'b0;
    @(negedge clk); dac_tick = 1'b0; chk("R10 pass", dac_data, 16'h1234);
    pb_sample = 16'hBEEF;
    @(negedge clk); chk("R10 idle hold", dac_data, 16'h1234);
    dac_tick = 1'b1; underrun = 1'b1;
    @(negedge clk); dac_tick = 1'b0; underrun = 1'b0;
    chk("R9 hold on underrun", dac_data, 16'h1234);
    wr(5'd16, 8'h01);
    @(negedge clk); dac_tick = 1'b1; underrun = 1'b1;
    @(negedge clk); dac_tick = 1'b0; underrun = 1'b0;
    chk("R8 center on underrun", dac_data, 16'h8000);
    dac_tick = 1'b1;
    @(negedge clk); dac_tick = 1'b0; chk("R10 pass after zero", dac_data, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_base(); t_compat(); t_feature();
    t_fmt(); t_filter(); t_unmapped(); t_dac();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule